// File: doc/BRIEF.md
# Receive-Only Burst Engine for an SPI Host

This block runs the receive-only leg of an SPI host. Software writes a byte count into a request port. The engine then keeps the serial clock running with the transmitter off until exactly that many bytes have been shifted in. One bit is taken on each `bit_tick` pulse, most significant bit first. Baud-rate generation is outside this block and arrives as the tick.

The word width set for normal transfers does not apply in this mode. Received bytes are always gathered into 32-bit words and written to a small receive FIFO. A burst whose length is not a multiple of four ends with a short word. Each FIFO entry carries a byte-valid count, so the reader knows how many low-order bytes of that word hold data.

A down-counter shows how many bytes are still outstanding. A control word sets the FIFO enable and the interrupt trigger level, and can flush the FIFO. A word that completes while the FIFO is full is discarded and raises an overflow pulse.

Top module: `rx_burst_engine`

## Requirements
- R1: After reset, the to-do count is 0, the FIFO is empty, `shift_en` is 0, and `rx_irq` and `rx_ovf` are both 0.
- R2: A request write is accepted only while the engine is idle with the FIFO enabled. It loads `todo_bytes` with `req_bytes` on the next clock edge. `shift_en` is 1 exactly while `todo_bytes` is non-zero. Bit ticks that arrive while idle shift nothing and produce no `sck_tick`.
- R3: Each group of eight ticks taken while active forms one byte, with the first bit as the byte's MSB. `todo_bytes` drops by one at the edge that takes the eighth bit.
- R4: Four consecutive bytes form one FIFO word with the first byte in bits [31:24] and the fourth in [7:0]. The word's byte-valid count is 4.
- R5: When a burst ends after n = 1..3 bytes of a word, that word is pushed with its bytes in the low n byte lanes, first byte most significant. Its byte-valid count is n. `rd_vbytes` is always in 1..4 while the FIFO holds data.
- R6: A word that completes while the FIFO already holds DEPTH entries is dropped, and `rx_ovf` pulses high for one cycle on the following clock. A burst of up to 4 x DEPTH bytes with no reads never overflows.
- R7: `rx_irq` is high when the FIFO is enabled and non-empty, and either the fill level is at least the trigger level or `todo_bytes` is 0.
- R8: A control write sets the FIFO enable from bit 0 and the trigger level from bits [15:8]. If bit 1 (flush) is set, the FIFO is emptied, any partly built word is discarded and `todo_bytes` goes to 0, all on the next edge.
- R9: Request writes are ignored while `todo_bytes` is non-zero, while the FIFO is disabled, or when the count is 0.
- R10: `fifo_stat[7:0]` gives the receive fill level. `fifo_stat[15:8]`, the transmit fill level, reads 0 in this mode.
- R11: `rd_word`/`rd_vbytes` show the oldest entry. `rd_pop` removes it. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per serial bit time |
| sdi | input | 1 | Serial data in |
| req_wr | input | 1 | Request count write strobe |
| req_bytes | input | 16 | Number of bytes to receive |
| fctl_wr | input | 1 | FIFO control write strobe |
| fctl_wdata | input | 16 | Control word: [15:8] trigger, [1] flush, [0] enable |
| rd_pop | input | 1 | Remove the oldest FIFO entry |
| rd_word | output | 32 | Oldest FIFO word |
| rd_vbytes | output | 3 | Valid byte count of the oldest word (1..4) |
| todo_bytes | output | 16 | Bytes still to be received |
| fifo_stat | output | 16 | [7:0] receive level, [15:8] transmit level (0) |
| shift_en | output | 1 | Serial clock running |
| sck_tick | output | 1 | A bit is being shifted in this cycle |
| rx_irq | output | 1 | Receive interrupt |
| rx_ovf | output | 1 | One-cycle pulse when a word is dropped |

## Verification
The bench sweeps every burst length from 1 to 4 x DEPTH bytes and rebuilds each expected word and valid count arithmetically. A packer that put short words in the wrong lanes, or that missed the final partial push, would show up as wrong words or a short FIFO level. The largest burst must fill the FIFO exactly without overflow. A burst four bytes longer must drop exactly one word, while the first four words stay intact. A separate run flushes in the middle of a byte to check that no stale bits leak into the next burst. The bench also fires requests that should be ignored (while busy, while disabled, or with a count of zero) and ticks while idle. A design that took any of these would change `todo_bytes` or the fill level. The trigger level is tested just below and at its threshold.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int VB_W    = 3;
  localparam int CTL_W   = 16;
  localparam int TRIG_LO = 8;
  localparam int TRIG_W  = 8;
  localparam int FLUSH_B = 1;
  localparam int EN_B    = 0;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [VB_W-1:0]   nbytes;
  } rx_entry_t;

  // shift a new byte into the low lane, older bytes move up
  function automatic logic [WORD_W-1:0] append_byte(input logic [WORD_W-1:0] acc,
                                                    input logic [BYTE_W-1:0] b);
    return {acc[WORD_W-BYTE_W-1:0], b};
  endfunction

  function automatic logic level_hit(input int unsigned lvl, input int unsigned trg);
    return lvl >= trg;
  endfunction

endpackage

// File: rtl/rxb_bit_shift.sv
module rxb_bit_shift
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              sdi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0] shreg;

  assign byte_done = sample && (bit_cnt == BC_W'(BYTE_W-1));
  assign byte_val  = {shreg, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sample) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {shreg[BYTE_W-3:0], sdi};
    end
  end
endmodule

// File: rtl/rxb_packer.sv
module rxb_packer
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              last_byte,
  output logic              push,
  output rx_entry_t         entry
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int LN_W  = $clog2(LANES);

  logic [WORD_W-1:0] acc;
  logic [LN_W-1:0]   lane;

  assign push         = byte_done && ((lane == LN_W'(LANES-1)) || last_byte);
  assign entry.word   = append_byte(acc, byte_val);
  assign entry.nbytes = VB_W'(lane) + VB_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      lane <= '0;
    end else if (clear || push) begin
      acc  <= '0;
      lane <= '0;
    end else if (byte_done) begin
      acc  <= append_byte(acc, byte_val);
      lane <= lane + 1'b1;
    end
  end
endmodule

// File: rtl/rxb_word_fifo.sv
module rxb_word_fifo
  import rxb_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  rx_entry_t        wentry,
  input  logic             pop,
  output rx_entry_t        head,
  output logic [LVL_W-1:0] level,
  output logic             drop
);
  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, empty, do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rx_burst_engine.sv
module rx_burst_engine
  import rxb_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sdi,
  input  logic              req_wr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              fctl_wr,
  input  logic [CTL_W-1:0]  fctl_wdata,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_word,
  output logic [VB_W-1:0]   rd_vbytes,
  output logic [CNT_W-1:0]  todo_bytes,
  output logic [15:0]       fifo_stat,
  output logic              shift_en,
  output logic              sck_tick,
  output logic              rx_irq,
  output logic              rx_ovf
);
  logic              fifo_en;
  logic [TRIG_W-1:0] trig_lvl;
  logic              flush_req, req_take;
  logic              byte_done, word_push, word_drop;
  logic [BYTE_W-1:0] byte_val;
  rx_entry_t         push_entry, head;
  logic [LVL_W-1:0]  fifo_level;

  assign flush_req = fctl_wr && fctl_wdata[FLUSH_B];
  assign req_take  = req_wr && (todo_bytes == '0) && fifo_en
                     && (req_bytes != '0) && !flush_req;
  assign shift_en  = (todo_bytes != '0);
  assign sck_tick  = shift_en && bit_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_lvl <= '0;
    end else if (fctl_wr) begin
      fifo_en  <= fctl_wdata[EN_B];
      trig_lvl <= fctl_wdata[TRIG_LO +: TRIG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         todo_bytes <= '0;
    else if (flush_req) todo_bytes <= '0;
    else if (req_take)  todo_bytes <= req_bytes;
    else if (byte_done) todo_bytes <= todo_bytes - 1'b1;
  end

  rxb_bit_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_req),
    .sample    (sck_tick),
    .sdi       (sdi),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  rxb_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_req),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .last_byte (todo_bytes == CNT_W'(1)),
    .push      (word_push),
    .entry     (push_entry)
  );

  rxb_word_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush_req),
    .push   (word_push),
    .wentry (push_entry),
    .pop    (rd_pop),
    .head   (head),
    .level  (fifo_level),
    .drop   (word_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_ovf <= 1'b0;
    else        rx_ovf <= word_drop;
  end

  assign rd_word   = head.word;
  assign rd_vbytes = head.nbytes;
  assign fifo_stat = {8'h00, 8'(fifo_level)};
  assign rx_irq    = fifo_en && (fifo_level != '0)
                     && (level_hit(int'(fifo_level), int'(trig_lvl)) || (todo_bytes == '0));
endmodule

// File: rtl/rxb_engine_chk.sv
module rxb_engine_chk #(
  parameter  int DEPTH = 4,
  parameter  int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_wr,
  input logic             fctl_wr,
  input logic [15:0]      fctl_wdata,
  input logic [CNT_W-1:0] todo_bytes,
  input logic [LVL_W-1:0] fifo_level,
  input logic [2:0]       rd_vbytes,
  input logic             word_push,
  input logic             word_drop,
  input logic             rx_irq,
  input logic             rx_ovf
);
  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> $past(fifo_level) == LVL_W'(DEPTH));

  assert_drop_needs_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_drop |-> word_push);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fctl_wr && fctl_wdata[1]) |=> (todo_bytes == '0 && fifo_level == '0));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (todo_bytes == '0 && !req_wr) |=> todo_bytes == '0);

  assert_todo_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (todo_bytes != '0 && !fctl_wr) |=>
      (todo_bytes == $past(todo_bytes) || todo_bytes == $past(todo_bytes) - CNT_W'(1)));

  assert_irq_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> fifo_level != '0);

  assert_vbytes_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0) |-> (rd_vbytes >= 3'd1 && rd_vbytes <= 3'd4));
endmodule

bind rx_burst_engine rxb_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_wr     (req_wr),
  .fctl_wr    (fctl_wr),
  .fctl_wdata (fctl_wdata),
  .todo_bytes (todo_bytes),
  .fifo_level (fifo_level),
  .rd_vbytes  (rd_vbytes),
  .word_push  (word_push),
  .word_drop  (word_drop),
  .rx_irq     (rx_irq),
  .rx_ovf     (rx_ovf)
);

// File: tb/rx_burst_engine_test.sv
module rx_burst_engine_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, sdi = 1'b0;
  logic        req_wr = 1'b0, fctl_wr = 1'b0, rd_pop = 1'b0;
  logic [15:0] req_bytes = '0, fctl_wdata = '0;
  logic [31:0] rd_word;
  logic [2:0]  rd_vbytes;
  logic [15:0] todo_bytes, fifo_stat;
  logic        shift_en, sck_tick, rx_irq, rx_ovf;

  int checks = 0, errors = 0, ovf_cnt = 0;

  always #10 clk = ~clk;

  rx_burst_engine #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sdi(sdi),
    .req_wr(req_wr), .req_bytes(req_bytes), .fctl_wr(fctl_wr),
    .fctl_wdata(fctl_wdata), .rd_pop(rd_pop), .rd_word(rd_word),
    .rd_vbytes(rd_vbytes), .todo_bytes(todo_bytes), .fifo_stat(fifo_stat),
    .shift_en(shift_en), .sck_tick(sck_tick), .rx_irq(rx_irq), .rx_ovf(rx_ovf)
  );

  always @(negedge clk) if (rx_ovf) ovf_cnt++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int run, input int k);
    return 8'(run * 37 + k * 11 + 5);
  endfunction

  function automatic int nb_of(input int n, input int i);
    return (n - 4 * i > 4) ? 4 : n - 4 * i;
  endfunction

  function automatic logic [31:0] exp_word(input int run, input int n, input int i);
    logic [31:0] w = '0;
    for (int j = 0; j < nb_of(n, i); j++) w = (w << 8) | 32'(pat(run, 4 * i + j));
    return w;
  endfunction

  task automatic ctl(input logic [7:0] trig, input bit flush, input bit en);
    @(negedge clk);
    fctl_wr = 1'b1; fctl_wdata = {trig, 6'd0, flush, en};
    @(negedge clk);
    fctl_wr = 1'b0;
  endtask

  task automatic request(input int n);
    @(negedge clk);
    req_wr = 1'b1; req_bytes = 16'(n);
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic shift_bytes(input int run, input int first, input int cnt);
    for (int k = first; k < first + cnt; k++) begin
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk);
        sdi = pat(run, k)[b]; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
      end
    end
  endtask

  task automatic pop1;
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic drain_check(input int run, input int n, input int words);
    for (int i = 0; i < words; i++) begin
      if (nb_of(n, i) == 4) begin
        check(rd_word == exp_word(run, n, i), "R4 full word", rd_word, exp_word(run, n, i));
        check(rd_vbytes == 3'd4, "R4 vbytes", 32'(rd_vbytes), 32'd4);
      end else begin
        check(rd_word == exp_word(run, n, i), "R5 partial word", rd_word, exp_word(run, n, i));
        check(int'(rd_vbytes) == nb_of(n, i), "R5 vbytes", 32'(rd_vbytes), 32'(nb_of(n, i)));
      end
      pop1();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(todo_bytes == 0, "R1 todo", 32'(todo_bytes), 0);
    check(fifo_stat == 0, "R1 level", 32'(fifo_stat), 0);
    check(!shift_en && !rx_irq && !rx_ovf, "R1 flags", {shift_en, rx_irq, rx_ovf}, 0);

    request(5);
    check(todo_bytes == 0, "R9 disabled request", 32'(todo_bytes), 0);

    ctl(8'(DEPTH), 1'b0, 1'b1);
    for (int n = 1; n <= 4 * DEPTH; n++) begin
      request(n);
      check(todo_bytes == 16'(n), "R2 load", 32'(todo_bytes), 32'(n));
      check(shift_en, "R2 shift_en", 32'(shift_en), 1);
      shift_bytes(n, 0, n);
      check(todo_bytes == 0 && !shift_en, "R3 count done", 32'(todo_bytes), 0);
      check(int'(fifo_stat) == (n + 3) / 4, "R10 level", 32'(fifo_stat), 32'((n + 3) / 4));
      check(rx_irq, "R7 irq at end", 32'(rx_irq), 1);
      drain_check(n, n, (n + 3) / 4);
      check(fifo_stat == 0 && !rx_irq, "R11 drained", 32'(fifo_stat), 0);
    end
    repeat (2) @(negedge clk);
    check(ovf_cnt == 0, "R6 no overflow up to 4xDEPTH", 32'(ovf_cnt), 0);

    request(3);
    shift_bytes(50, 0, 1);
    check(todo_bytes == 2, "R3 one byte", 32'(todo_bytes), 2);
    check(!rx_irq, "R7 no irq empty", 32'(rx_irq), 0);
    request(9);
    check(todo_bytes == 2, "R9 busy request", 32'(todo_bytes), 2);
    shift_bytes(50, 1, 0);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); sdi = 1'b1; bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    ctl(8'(DEPTH), 1'b1, 1'b1);
    check(todo_bytes == 0 && !shift_en, "R8 flush todo", 32'(todo_bytes), 0);
    check(fifo_stat == 0, "R8 flush level", 32'(fifo_stat), 0);
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk);
    check(!sck_tick, "R2 idle tick", 32'(sck_tick), 0);
    bit_tick = 1'b0;
    for (int b = 0; b < 15; b++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    check(todo_bytes == 0 && fifo_stat == 0, "R2 idle ticks ignored", 32'(fifo_stat), 0);
    request(2);
    shift_bytes(51, 0, 2);
    drain_check(51, 2, 1);

    ctl(8'd2, 1'b0, 1'b1);
    request(12);
    shift_bytes(60, 0, 4);
    check(fifo_stat == 1 && todo_bytes == 8, "R7 below trigger level", 32'(fifo_stat), 1);
    check(!rx_irq, "R7 below trigger", 32'(rx_irq), 0);
    shift_bytes(60, 4, 4);
    check(rx_irq, "R7 at trigger", 32'(rx_irq), 1);
    shift_bytes(60, 8, 4);
    drain_check(60, 12, 3);
    pop1();
    check(fifo_stat == 0, "R11 pop empty", 32'(fifo_stat), 0);

    ctl(8'(DEPTH), 1'b0, 1'b1);
    request(4 * DEPTH + 4);
    shift_bytes(70, 0, 4 * DEPTH + 4);
    repeat (2) @(negedge clk);
    check(ovf_cnt == 1, "R6 one drop", 32'(ovf_cnt), 1);
    check(int'(fifo_stat) == DEPTH, "R6 full level", 32'(fifo_stat), 32'(DEPTH));
    drain_check(70, 4 * DEPTH + 4, DEPTH);

    request(0);
    check(todo_bytes == 0 && !shift_en, "R9 zero request", 32'(todo_bytes), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule